// File: doc/BRIEF.md
# Overcurrent Chopping Limiter for Low-Side Drive Channels

This block sits between the on/off commands for a bank of low-side switches and their gate drive. Each channel takes a command bit and an overcurrent flag from an external current sensor. It produces one registered drive bit. A commanded channel with a healthy load conducts without interruption.

When the sensor reports overcurrent, the channel stops conducting for a long recovery window. It then retries with a short conduction window. If overcurrent is seen at any cycle of that retry window, another recovery window follows. With a shorted or overloaded load the channel settles into a low duty cycle of `ON_CYC / (ON_CYC + OFF_CYC)`, which is about 2 percent at the default settings. A retry window with no overcurrent returns the channel to steady conduction. A later overload puts it back into chopping.

Every channel has its own state machine and its own window counter, so a fault on one output never disturbs another. Both window lengths are parameters counted in clock cycles. The defaults, 2000 and 125000, give about 40 µs and 2.5 ms at 50 MHz.

Top module: `chop_limiter`

## Requirements
- R1: While `rstN` is low at a rising clock edge, every channel returns to idle and all `drive` bits are 0 after that edge, whatever `cmdOn` and `ovcFlag` hold.
- R2: A channel that is idle and sees `cmdOn` high at an edge has `drive` high after that edge. With no overcurrent it stays high for as long as the command is held.
- R3: A channel in steady conduction that sees `ovcFlag` high at an edge has `drive` low after that edge. `drive` then stays low for exactly `OFF_CYC` cycles.
- R4: At the end of a recovery window, a channel that is still commanded drives high for exactly `ON_CYC` cycles (the retry window).
- R5: Overcurrent sampled at any edge of the retry window, even for a single cycle, starts a new recovery window when the retry window ends. A permanent overload therefore repeats `ON_CYC` high cycles and `OFF_CYC` low cycles.
- R6: A retry window in which no overcurrent is sampled is followed by steady conduction, with `drive` staying high.
- R7: `ovcFlag` is ignored while `drive` is low. During a recovery window it neither shortens nor lengthens the window. While the channel is commanded off it has no effect on the next turn-on.
- R8: `cmdOn` low at an edge forces `drive` low after that edge, from any state. A fresh command afterwards starts in steady conduction with both windows cleared.
- R9: Channels are independent: overcurrent and chopping on one channel leave the `drive` of every other channel unchanged.
- R10: A channel that returned to steady conduction re-enters chopping when overcurrent reappears, dropping `drive` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| cmdOn | input | NUM_CH | Per-channel conduction command, 1 = on |
| ovcFlag | input | NUM_CH | Per-channel overcurrent indication from the sensor, 1 = over the limit |
| drive | output | NUM_CH | Registered per-channel gate drive, 1 = conducting |

## Verification
The bench measures the exact lengths of the high and low runs of `drive`. This exposes a window that is off by one cycle, or a counter that is not cleared when a window starts. One test is a single-cycle overcurrent pulse in the middle of a retry window. A design that looked only at the last cycle of that window would return to steady conduction instead of tripping again. Another test toggles overcurrent during the recovery window and while the channel is commanded off. A design that honoured the flag there would restart the recovery window or chop after the next turn-on. A neighbouring channel is held on throughout the chopping tests, which catches any shared timer or cross-channel coupling.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // Per-channel operating state
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,  // not commanded, drive off
    CH_CONT  = 2'd1,  // steady conduction
    CH_PULSE = 2'd2,  // retry conduction window
    CH_REST  = 2'd3   // forced-off recovery window
  } chop_state_e;

  // Strobes from the control FSM to the window datapath
  typedef struct packed {
    logic restart;  // a new state begins: clear count and overcurrent memory
    logic track;    // accumulate overcurrent samples (retry window active)
  } chop_strobe_t;

endpackage

// File: rtl/chop_timer.sv
module chop_timer
  import chop_pkg::*;
#(
  parameter int unsigned ON_CYC  = 2000,
  parameter int unsigned OFF_CYC = 125000
) (
  input  logic         clk,
  input  logic         rstN,
  input  chop_strobe_t strobe,
  input  logic         ovc,
  output logic         pulseDone,
  output logic         restDone,
  output logic         ovcSeen
);

  localparam int unsigned MAX_CYC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_CYC - 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MAX_CYC);

  logic [CNT_W-1:0] winCnt;
  logic             seenQ;

  // One counter serves both windows; only one window is active at a time.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
      seenQ  <= 1'b0;
    end else if (strobe.restart) begin
      winCnt <= '0;
      seenQ  <= 1'b0;
    end else begin
      if (winCnt != CNT_SAT) winCnt <= winCnt + 1'b1;
      seenQ <= seenQ | (strobe.track & ovc);
    end
  end

  assign pulseDone = (winCnt == ON_LAST);
  assign restDone  = (winCnt == OFF_LAST);
  assign ovcSeen   = seenQ;

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdOn,
  input  logic         ovc,
  input  logic         pulseDone,
  input  logic         restDone,
  input  logic         ovcSeen,
  output chop_strobe_t strobe,
  output chop_state_e  state,
  output logic         drive
);

  chop_state_e nextState;

  always_comb begin
    nextState = state;
    if (!cmdOn) begin
      nextState = CH_IDLE;
    end else begin
      case (state)
        CH_IDLE:  nextState = CH_CONT;
        CH_CONT:  if (ovc) nextState = CH_REST;
        CH_REST:  if (restDone) nextState = CH_PULSE;
        CH_PULSE: if (pulseDone) nextState = (ovcSeen || ovc) ? CH_REST : CH_CONT;
        default:  nextState = CH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.restart = (nextState != state);
    strobe.track   = (state == CH_PULSE);
  end

  // Drive is registered from the next state so the gate sees no decode glitch.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= CH_IDLE;
      drive <= 1'b0;
    end else begin
      state <= nextState;
      drive <= (nextState == CH_CONT) || (nextState == CH_PULSE);
    end
  end

endmodule

// File: rtl/chop_limiter.sv
module chop_limiter
  import chop_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned ON_CYC  = 2000,
  parameter int unsigned OFF_CYC = 125000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmdOn,
  input  logic [NUM_CH-1:0] ovcFlag,
  output logic [NUM_CH-1:0] drive
);

  chop_state_e [NUM_CH-1:0] chState;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      chop_strobe_t strobe;
      logic         pulseDone;
      logic         restDone;
      logic         ovcSeen;

      chop_ctrl ctrl_i (
        .clk       (clk),
        .rstN      (rstN),
        .cmdOn     (cmdOn[g]),
        .ovc       (ovcFlag[g]),
        .pulseDone (pulseDone),
        .restDone  (restDone),
        .ovcSeen   (ovcSeen),
        .strobe    (strobe),
        .state     (chState[g]),
        .drive     (drive[g])
      );

      chop_timer #(
        .ON_CYC  (ON_CYC),
        .OFF_CYC (OFF_CYC)
      ) timer_i (
        .clk       (clk),
        .rstN      (rstN),
        .strobe    (strobe),
        .ovc       (ovcFlag[g]),
        .pulseDone (pulseDone),
        .restDone  (restDone),
        .ovcSeen   (ovcSeen)
      );
    end
  endgenerate

endmodule

// File: rtl/chop_limiter_chk.sv
module chop_limiter_chk
  import chop_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned ON_CYC  = 2000,
  parameter int unsigned OFF_CYC = 125000
) (
  input logic                     clk,
  input logic                     rstN,
  input logic        [NUM_CH-1:0] cmdOn,
  input logic        [NUM_CH-1:0] ovcFlag,
  input logic        [NUM_CH-1:0] drive,
  input chop_state_e [NUM_CH-1:0] chState
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> (drive == '0));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      int unsigned restRun;
      int unsigned pulseRun;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          restRun  <= 0;
          pulseRun <= 0;
        end else begin
          restRun  <= (chState[g] == CH_REST)  ? restRun + 1  : 0;
          pulseRun <= (chState[g] == CH_PULSE) ? pulseRun + 1 : 0;
        end
      end

      // R8
      cmd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
        !cmdOn[g] |=> !drive[g]);

      // R2
      turn_on_chk: assert property (@(posedge clk) disable iff (!rstN)
        (chState[g] == CH_IDLE && cmdOn[g]) |=> (chState[g] == CH_CONT && drive[g]));

      // R3
      trip_chk: assert property (@(posedge clk) disable iff (!rstN)
        (chState[g] == CH_CONT && cmdOn[g] && ovcFlag[g]) |=> (chState[g] == CH_REST && !drive[g]));

      // R3
      rest_len_chk: assert property (@(posedge clk) disable iff (!rstN)
        (chState[g] == CH_REST) |-> (restRun < OFF_CYC));

      // R4
      pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
        (chState[g] == CH_PULSE) |-> (pulseRun < ON_CYC));

      // R7
      rest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (chState[g] == CH_REST && cmdOn[g]) |=> (chState[g] == CH_REST || chState[g] == CH_PULSE));
    end
  endgenerate

endmodule

bind chop_limiter chop_limiter_chk #(
  .NUM_CH  (NUM_CH),
  .ON_CYC  (ON_CYC),
  .OFF_CYC (OFF_CYC)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cmdOn   (cmdOn),
  .ovcFlag (ovcFlag),
  .drive   (drive),
  .chState (chState)
);

// File: tb/chop_limiter_tb_top.sv
module chop_limiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 8;
  localparam int ONC  = 4;
  localparam int OFFC = 12;
  localparam int LONG = 30;

  logic           clk = 1'b0;
  logic           rstN;
  logic [NCH-1:0] cmdOn;
  logic [NCH-1:0] ovcFlag;
  logic [NCH-1:0] drive;

  int  testsRun    = 0;
  int  testsFailed = 0;
  bit  finished    = 1'b0;
  bit  watch3      = 1'b0;
  int  ch3Lows     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chop_limiter #(.NUM_CH(NCH), .ON_CYC(ONC), .OFF_CYC(OFFC)) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .cmdOn   (cmdOn),
    .ovcFlag (ovcFlag),
    .drive   (drive)
  );

  always @(negedge clk) if (watch3 && !drive[3]) ch3Lows++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count consecutive negedges on which drive[ch] equals level, from the current one.
  task automatic runLen(input int ch, input bit level, input int limit, output int n);
    n = 0;
    while (drive[ch] == level && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0; cmdOn = '1; ovcFlag = '0;
    repeat (3) @(negedge clk);
    check(drive == '0, "R1 drive during reset", int'(drive), 0);
    cmdOn = '0; rstN = 1'b1;
    @(negedge clk);
    check(drive == '0, "R1 drive after reset", int'(drive), 0);
  endtask

  task automatic t_turnOn();
    int n;
    cmdOn[0] = 1'b1; cmdOn[3] = 1'b1;
    @(negedge clk);
    check(drive[0] == 1'b1, "R2 drive one cycle after command", drive[0], 1);
    runLen(0, 1'b1, LONG, n);
    check(n == LONG, "R2 steady conduction length", n, LONG);
  endtask

  task automatic t_persistent();
    int n;
    watch3 = 1'b1;
    ovcFlag[0] = 1'b1;
    @(negedge clk);
    check(drive[0] == 1'b0, "R3 trip at next edge", drive[0], 0);
    runLen(0, 1'b0, 100, n);
    check(n == OFFC, "R3 recovery window length", n, OFFC);
    runLen(0, 1'b1, 100, n);
    check(n == ONC, "R4 retry window length", n, ONC);
    runLen(0, 1'b0, 100, n);
    check(n == OFFC, "R5 second recovery window", n, OFFC);
    runLen(0, 1'b1, 100, n);
    check(n == ONC, "R5 second retry window", n, ONC);
    check(ch3Lows == 0, "R9 neighbour stays on", ch3Lows, 0);
    check(drive[NCH-1:4] == '0, "R9 idle channels stay off", int'(drive[NCH-1:4]), 0);
  endtask

  // Entered on the first low negedge of a recovery window, overcurrent high.
  task automatic t_recover();
    int n;
    ovcFlag[0] = 1'b0;
    @(negedge clk);
    ovcFlag[0] = 1'b1;
    @(negedge clk);
    ovcFlag[0] = 1'b0;
    runLen(0, 1'b0, 100, n);
    check(n + 2 == OFFC, "R7 toggled overcurrent keeps recovery length", n + 2, OFFC);
    runLen(0, 1'b1, ONC + LONG, n);
    check(n == ONC + LONG, "R6 clean retry returns to steady conduction", n, ONC + LONG);
    ovcFlag[0] = 1'b1;
    @(negedge clk);
    check(drive[0] == 1'b0, "R10 re-trip from steady conduction", drive[0], 0);
    runLen(0, 1'b0, 100, n);
    check(n == OFFC, "R10 recovery after re-trip", n, OFFC);
  endtask

  // Entered on the first high negedge of a retry window.
  task automatic t_pulse();
    int n;
    ovcFlag[0] = 1'b0;
    @(negedge clk);
    ovcFlag[0] = 1'b1;
    @(negedge clk);
    ovcFlag[0] = 1'b0;
    runLen(0, 1'b1, 100, n);
    check(n + 2 == ONC, "R5 retry window with single-cycle pulse", n + 2, ONC);
    runLen(0, 1'b0, 100, n);
    check(n == OFFC, "R5 single-cycle pulse causes new recovery", n, OFFC);
    runLen(0, 1'b1, ONC + LONG, n);
    check(n == ONC + LONG, "R6 steady after clean retry", n, ONC + LONG);
    check(ch3Lows == 0, "R9 neighbour stays on through chopping", ch3Lows, 0);
    watch3 = 1'b0;
  endtask

  task automatic t_cmdOff();
    int n;
    ovcFlag[0] = 1'b1;
    @(negedge clk);
    cmdOn[0] = 1'b0;
    @(negedge clk);
    check(drive[0] == 1'b0, "R8 command off during recovery", drive[0], 0);
    runLen(0, 1'b0, 5, n);
    check(n == 5, "R7 overcurrent while off keeps drive low", n, 5);
    cmdOn[0] = 1'b1; ovcFlag[0] = 1'b0;
    @(negedge clk);
    check(drive[0] == 1'b1, "R8 fresh command conducts at once", drive[0], 1);
    runLen(0, 1'b1, ONC + OFFC + 10, n);
    check(n == ONC + OFFC + 10, "R8 fresh command conducts steadily", n, ONC + OFFC + 10);
    cmdOn[0] = 1'b0;
    @(negedge clk);
    check(drive[0] == 1'b0, "R8 command off from steady conduction", drive[0], 0);
    check(drive[3] == 1'b1, "R9 other channel unaffected by command off", drive[3], 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    rstN = 1'b0; cmdOn = '0; ovcFlag = '0;
    @(negedge clk);
    t_reset();
    t_turnOn();
    t_persistent();
    t_recover();
    t_pulse();
    t_cmdOff();
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule